// File: doc/BRIEF.md
# Streaming DMA Command Sequencer

This block sequences the transfers of a memory-to-stream data mover. Software programs a 64-bit buffer address (two 32-bit halves), a byte count and an idle-gap length through a small register port, then writes an operation code. The sequencer turns that operation into command words on a valid/ready command stream and consumes one status word per command on a status stream. It supports four operations: stay idle, run one transfer and park, run the same transfer back to back without end, or run it repeatedly with a programmable number of idle clocks between transfers.

Stopping a running operation is clean. The sequencer first waits for the status of the transfer that is still in flight, then holds a reset line to the data mover high for a fixed number of clocks, and only then returns to idle. A status word that reports an error parks the block in a fault state until software writes the idle operation again. The current state is exposed as a 4-bit code, both on a port and through the register port.

Top module: `dmseq_top`

## Requirements
- R1: After reset the state code is 0 (idle), `cmd_valid` is low and `mover_rst` is low.
- R2: Register addresses are 0 operation (bits 1:0: 0 idle, 1 one-shot, 2 continuous, 3 paced), 1 address low, 2 address high, 3 byte count, 4 gap length, 5 state code (read only). A byte count above 8388607 is stored as 8388607. The command word is {address high, address low, byte count[22:0]}: bits 86:55, 54:23 and 22:0.
- R3: With a byte count of 0, any non-idle operation leaves the state at idle and issues no command.
- R4: One-shot issues exactly one command; after its good status the state is 8 and stays there until the operation register holds idle, then returns to 0.
- R5: In continuous mode, the next command is presented in the same clock edge that accepts the good status of the previous one (zero gap), with the same command word.
- R6: In paced mode with gap length G > 0, the next command is presented exactly G clock edges after the edge that accepted the previous good status; the state code is 6 during the gap and 7 while a transfer runs.
- R7: Once `cmd_valid` is high it stays high with a stable `cmd_data` until `cmd_ready` is seen.
- R8: At most one command is outstanding: `cmd_valid` is never high while `sts_ready` is high.
- R9: Writing idle while a transfer is in flight moves to state 2 until its status is accepted, then to state 3 with `mover_rst` high for 4 clocks, then to 0. If the idle operation and the good status land in the same cycle, state 2 is skipped and no new command is issued.
- R10: A status word with any of bits 7:4 set moves to state 4; bits 3:0 are ignored. State 4 ignores non-idle writes and is left to 0 only by a write of the idle operation.
- R11: The state code read at address 5 equals the `state_code` port; codes are 0 idle, 1 continuous, 2 draining, 3 mover reset, 4 fault, 5 one-shot, 6 gap, 7 paced, 8 parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 3 | Register read address |
| reg_rd_data | output | 32 | Register read data (combinational) |
| cmd_valid | output | 1 | Command word valid |
| cmd_ready | input | 1 | Data mover accepts command |
| cmd_data | output | 87 | Command word {address, byte count} |
| sts_valid | input | 1 | Status word valid |
| sts_ready | output | 1 | Sequencer accepts status |
| sts_data | input | 8 | Status word, bits 7:4 error flags |
| mover_rst | output | 1 | Reset pulse to the data mover |
| state_code | output | 4 | Current sequencer state |

## Verification
The two functions that can meet in one cycle are the stop request and the acceptance of a good status in continuous mode: the same edge could either re-issue the transfer or start the shutdown. The bench provokes this by timing the idle write from the status model's own latency counter so the operation register turns idle exactly one cycle before the status is accepted. It then judges that the state goes straight to 3 without passing 2, that no extra command is handshaken, and that the mover reset still lasts four clocks.

// File: rtl/dmseq_pkg.sv
package dmseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_RUN   = 4'd1,
    ST_DRAIN = 4'd2,
    ST_FLUSH = 4'd3,
    ST_FAULT = 4'd4,
    ST_ONCE  = 4'd5,
    ST_GAP   = 4'd6,
    ST_PACED = 4'd7,
    ST_PARK  = 4'd8
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_ONCE  = 2'd1,
    OP_RUN   = 2'd2,
    OP_PACED = 2'd3
  } seq_op_e;

  localparam logic [2:0] RA_OP      = 3'd0;
  localparam logic [2:0] RA_ADDR_LO = 3'd1;
  localparam logic [2:0] RA_ADDR_HI = 3'd2;
  localparam logic [2:0] RA_LEN     = 3'd3;
  localparam logic [2:0] RA_GAP     = 3'd4;
  localparam logic [2:0] RA_STATE   = 3'd5;

endpackage

// File: rtl/dmseq_regs.sv
module dmseq_regs
  import dmseq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [2:0]            wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [2:0]            rd_addr,
  input  logic [3:0]            state_code,
  output logic [DATA_W-1:0]     rd_data,
  output seq_op_e               op,
  output logic [2*DATA_W-1:0]   base_addr,
  output logic [LEN_W-1:0]      len,
  output logic [DATA_W-1:0]     gap,
  output logic                  clr_pulse
);

  localparam logic [DATA_W-1:0] LEN_MAX   = {{(DATA_W-LEN_W){1'b0}}, {LEN_W{1'b1}}};
  localparam logic [LEN_W-1:0]  LEN_MAX_F = {LEN_W{1'b1}};

  seq_op_e           op_q;
  logic [DATA_W-1:0] lo_q, hi_q, gap_q;
  logic [LEN_W-1:0]  len_q;
  logic              we_op, we_lo, we_hi, we_len, we_gap;

  assign we_op  = wr_en && (wr_addr == RA_OP);
  assign we_lo  = wr_en && (wr_addr == RA_ADDR_LO);
  assign we_hi  = wr_en && (wr_addr == RA_ADDR_HI);
  assign we_len = wr_en && (wr_addr == RA_LEN);
  assign we_gap = wr_en && (wr_addr == RA_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_IDLE;
      lo_q  <= '0;
      hi_q  <= '0;
      len_q <= '0;
      gap_q <= '0;
    end else begin
      if (we_op)  op_q <= seq_op_e'(wr_data[1:0]);
      if (we_lo)  lo_q <= wr_data;
      if (we_hi)  hi_q <= wr_data;
      if (we_gap) gap_q <= wr_data;
      if (we_len) len_q <= (wr_data > LEN_MAX) ? LEN_MAX_F : wr_data[LEN_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_OP:      rd_data = {{(DATA_W-2){1'b0}}, op_q};
      RA_ADDR_LO: rd_data = lo_q;
      RA_ADDR_HI: rd_data = hi_q;
      RA_LEN:     rd_data = {{(DATA_W-LEN_W){1'b0}}, len_q};
      RA_GAP:     rd_data = gap_q;
      RA_STATE:   rd_data = {{(DATA_W-4){1'b0}}, state_code};
      default:    rd_data = '0;
    endcase
  end

  assign op        = op_q;
  assign base_addr = {hi_q, lo_q};
  assign len       = len_q;
  assign gap       = gap_q;
  assign clr_pulse = we_op && (wr_data[1:0] == OP_IDLE);

  // R2: oversized byte counts saturate at the field maximum
  p_len_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_len && (wr_data > LEN_MAX)) |=> (len_q == LEN_MAX_F));

endmodule

// File: rtl/dmseq_pace_cnt.sv
module dmseq_pace_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (en)  count <= count + 1'b1;
  end

endmodule

// File: rtl/dmseq_fsm.sv
module dmseq_fsm
  import dmseq_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          LEN_W     = 23,
  parameter int          STS_W     = 8,
  parameter int          FLUSH_CYC = 4,
  parameter logic [7:0]  ERR_MASK  = 8'hF0,
  localparam int         CMD_W     = 2*DATA_W + LEN_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  seq_op_e              op,
  input  logic [2*DATA_W-1:0]  base_addr,
  input  logic [LEN_W-1:0]     len,
  input  logic [DATA_W-1:0]    gap,
  input  logic                 clr_pulse,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [CMD_W-1:0]     cmd_data,
  input  logic                 sts_valid,
  output logic                 sts_ready,
  input  logic [STS_W-1:0]     sts_data,
  output logic                 mover_rst,
  output seq_state_e           state
);

  localparam logic [DATA_W-1:0] FLUSH_LAST = DATA_W'(FLUSH_CYC - 1);
  localparam logic [STS_W-1:0]  ERR_BITS   = STS_W'(ERR_MASK);

  seq_state_e        st_q, st_d;
  logic              cv_q, cv_d, out_q, out_d;
  logic [CMD_W-1:0]  word_q;
  logic [DATA_W-1:0] cnt;
  logic              sts_fire, sts_err, sts_ok, busy, stop_req, gap_done, issue_st;

  assign sts_fire = sts_valid && out_q;
  assign sts_err  = |(sts_data & ERR_BITS);
  assign sts_ok   = sts_fire && !sts_err;
  assign busy     = cv_q || out_q;
  assign stop_req = (op == OP_IDLE);
  assign gap_done = ({1'b0, cnt} + 1'b1) >= {1'b0, gap};

  dmseq_pace_cnt #(.W(DATA_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_q != st_d),
    .en    ((st_q == ST_GAP) || (st_q == ST_FLUSH)),
    .count (cnt)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:
        if (len != '0) begin
          if (op == OP_ONCE)       st_d = ST_ONCE;
          else if (op == OP_RUN)   st_d = ST_RUN;
          else if (op == OP_PACED) st_d = ST_PACED;
        end
      ST_ONCE:
        if (sts_fire) st_d = sts_err ? ST_FAULT : ST_PARK;
      ST_PARK:
        if (stop_req) st_d = ST_IDLE;
      ST_RUN:
        if (sts_fire && sts_err) st_d = ST_FAULT;
        else if (stop_req)       st_d = (busy && !sts_ok) ? ST_DRAIN : ST_FLUSH;
      ST_PACED:
        if (sts_fire && sts_err)       st_d = ST_FAULT;
        else if (stop_req)             st_d = (busy && !sts_ok) ? ST_DRAIN : ST_FLUSH;
        else if (sts_ok && gap != '0)  st_d = ST_GAP;
      ST_GAP:
        if (stop_req)      st_d = ST_FLUSH;
        else if (gap_done) st_d = ST_PACED;
      ST_DRAIN:
        if (sts_fire) st_d = sts_err ? ST_FAULT : ST_FLUSH;
      ST_FLUSH:
        if (cnt == FLUSH_LAST) st_d = ST_IDLE;
      ST_FAULT:
        if (clr_pulse) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign issue_st = (st_d == ST_ONCE) || (st_d == ST_RUN) || (st_d == ST_PACED);

  always_comb begin
    out_d = out_q ? !sts_fire : (cv_q && cmd_ready);
    cv_d  = cv_q  ? !cmd_ready : (issue_st && !out_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cv_q   <= 1'b0;
      out_q  <= 1'b0;
      word_q <= '0;
    end else begin
      st_q  <= st_d;
      cv_q  <= cv_d;
      out_q <= out_d;
      if (!cv_q && cv_d) word_q <= {base_addr, len};
    end
  end

  assign cmd_valid = cv_q;
  assign cmd_data  = word_q;
  assign sts_ready = out_q;
  assign mover_rst = (st_q == ST_FLUSH);
  assign state     = st_q;

  // R3: an empty transfer never leaves idle
  p_zero_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && len == '0) |=> (st_q == ST_IDLE && !cv_q));
  // R4: the parked state holds until the operation is idle
  p_park_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PARK && !stop_req) |=> (st_q == ST_PARK));
  // R5: continuous mode re-presents a command on the status edge
  p_b2b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && sts_ok && !stop_req) |=> cv_q);
  // R6: the gap only ends into the paced state or a shutdown
  p_gap_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP && !stop_req) |=> (st_q == ST_GAP || st_q == ST_PACED));
  // R7: valid holds with stable data until accepted
  p_hold_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_q && !cmd_ready) |=> (cv_q && $stable(word_q)));
  // R8: never a second command while one is outstanding
  p_one_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cv_q && out_q));
  // R9: a drained good status leads into the mover reset
  p_drain_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAIN && sts_ok) |=> (st_q == ST_FLUSH));
  // R10: an error status enters the fault state
  p_err_enter_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_fire && sts_err) |=> (st_q == ST_FAULT));
  // R10: the fault state is left only by an idle write
  p_fault_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FAULT && !clr_pulse) |=> (st_q == ST_FAULT));

endmodule

// File: rtl/dmseq_top.sv
module dmseq_top
  import dmseq_pkg::*;
#(
  parameter int         DATA_W    = 32,
  parameter int         LEN_W     = 23,
  parameter int         STS_W     = 8,
  parameter int         FLUSH_CYC = 4,
  parameter logic [7:0] ERR_MASK  = 8'hF0,
  localparam int        CMD_W     = 2*DATA_W + LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_wr_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic [2:0]        reg_rd_addr,
  output logic [DATA_W-1:0] reg_rd_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [CMD_W-1:0]  cmd_data,
  input  logic              sts_valid,
  output logic              sts_ready,
  input  logic [STS_W-1:0]  sts_data,
  output logic              mover_rst,
  output logic [3:0]        state_code
);

  logic                rst_meta, rst_s;
  seq_op_e             op;
  logic [2*DATA_W-1:0] base_addr;
  logic [LEN_W-1:0]    len;
  logic [DATA_W-1:0]   gap;
  logic                clr_pulse;
  seq_state_e          state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  dmseq_regs #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_s),
    .wr_en      (reg_wr_en),
    .wr_addr    (reg_wr_addr),
    .wr_data    (reg_wr_data),
    .rd_addr    (reg_rd_addr),
    .state_code (state_code),
    .rd_data    (reg_rd_data),
    .op         (op),
    .base_addr  (base_addr),
    .len        (len),
    .gap        (gap),
    .clr_pulse  (clr_pulse)
  );

  dmseq_fsm #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .STS_W(STS_W),
    .FLUSH_CYC(FLUSH_CYC), .ERR_MASK(ERR_MASK)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_s),
    .op        (op),
    .base_addr (base_addr),
    .len       (len),
    .gap       (gap),
    .clr_pulse (clr_pulse),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_data  (cmd_data),
    .sts_valid (sts_valid),
    .sts_ready (sts_ready),
    .sts_data  (sts_data),
    .mover_rst (mover_rst),
    .state     (state)
  );

  assign state_code = state;

  // R1: nothing is issued and the mover is not reset right out of reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(rst_s) |-> (!cmd_valid && !mover_rst));

endmodule

// File: tb/tb_dmseq_top.sv
`timescale 1ns/1ps
module tb_dmseq_top;

  localparam int READY_DLY = 2;
  localparam int STS_LAT   = 8;
  localparam int FLUSH_CYC = 4;

  logic        clk, rst_n;
  logic        reg_wr_en;
  logic [2:0]  reg_wr_addr, reg_rd_addr;
  logic [31:0] reg_wr_data, reg_rd_data;
  logic        cmd_valid, cmd_ready, sts_valid, sts_ready, mover_rst;
  logic [86:0] cmd_data;
  logic [7:0]  sts_data;
  logic [3:0]  state_code;

  int checks = 0, errors = 0, cyc = 0;
  int hs_count = 0, ovl = 0, last_sts_edge = -1;
  int rdy_cnt = 0, lat = 0;
  bit busy = 0, cv_prev = 0, err_next = 0, done = 0;
  logic [86:0] exp_q[$];
  int          gap_q[$];

  dmseq_top dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .sts_valid(sts_valid), .sts_ready(sts_ready), .sts_data(sts_data),
    .mover_rst(mover_rst), .state_code(state_code)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd_addr = a;
    #1;
    chk(reg_rd_data == exp, tag, reg_rd_data, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_hs(input int target);
    for (int i = 0; i < 400 && hs_count < target; i++) @(negedge clk);
  endtask

  task automatic push_exp(input logic [86:0] w, input int n);
    exp_q.delete();
    for (int i = 0; i < n; i++) exp_q.push_back(w);
  endtask

  // monitor and data-mover model: accepts commands, returns status, scores words
  initial begin
    cmd_ready = 1'b0; sts_valid = 1'b0; sts_data = '0;
    forever begin
      @(negedge clk);
      if (cmd_valid && !cv_prev && last_sts_edge >= 0) begin
        gap_q.push_back(cyc - last_sts_edge);
        last_sts_edge = -1;
      end
      cv_prev = cmd_valid;
      if (cmd_valid && sts_ready) ovl++;
      cmd_ready = 1'b0;
      sts_valid = 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          if (rdy_cnt == READY_DLY) begin
            cmd_ready = 1'b1; busy = 1; lat = 0; rdy_cnt = 0; hs_count++;
            checks++;
            if (exp_q.size() == 0) begin
              errors++;
              $display("FAIL R7 unexpected command act=%h exp=none", cmd_data);
            end else begin
              logic [86:0] e;
              e = exp_q.pop_front();
              if (cmd_data !== e) begin
                errors++;
                $display("FAIL R2/R7 command word act=%h exp=%h", cmd_data, e);
              end
            end
          end else rdy_cnt++;
        end
      end else begin
        lat++;
        if (lat == STS_LAT) begin
          sts_valid = 1'b1;
          sts_data  = err_next ? 8'h13 : 8'h05;
          busy = 0;
          if (!err_next) last_sts_edge = cyc + 1;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base, rcnt;
    bit saw_drain, first_ok;
    logic [86:0] w;
    reg_wr_en = 0; reg_wr_addr = '0; reg_wr_data = '0; reg_rd_addr = '0;
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk(state_code == 4'd0, "R1 state", state_code, 0);
    chk(!cmd_valid && !mover_rst, "R1 outputs", {cmd_valid, mover_rst}, 0);

    // R2 register file and clamp
    wr(3'd1, 32'h89AB_CDEF);
    wr(3'd2, 32'h0000_0012);
    wr(3'd3, 32'h0100_0000);
    rd_chk(3'd3, 32'd8388607, "R2 len clamp");
    rd_chk(3'd1, 32'h89AB_CDEF, "R2 addr lo");
    rd_chk(3'd2, 32'h0000_0012, "R2 addr hi");
    wr(3'd4, 32'd77);
    rd_chk(3'd4, 32'd77, "R2 gap reg");

    // R3 zero length is a no-op
    wr(3'd3, 32'd0);
    base = hs_count;
    wr(3'd0, 32'd2);
    idle(10);
    chk(state_code == 4'd0, "R3 state stays idle", state_code, 0);
    chk(hs_count == base, "R3 no command", hs_count - base, 0);
    wr(3'd0, 32'd0);

    // R4 one-shot
    wr(3'd3, 32'd1000);
    w = {32'h0000_0012, 32'h89AB_CDEF, 23'd1000};
    push_exp(w, 1);
    base = hs_count;
    wr(3'd0, 32'd1);
    idle(40);
    chk(hs_count == base + 1, "R4 exactly one command", hs_count - base, 1);
    chk(state_code == 4'd8, "R4 parked", state_code, 8);
    rd_chk(3'd5, 32'd8, "R11 state readback");
    wr(3'd0, 32'd0);
    idle(2);
    chk(state_code == 4'd0, "R4 back to idle", state_code, 0);

    // R5 continuous back-to-back, then R9 drain on stop
    wr(3'd3, 32'd4096);
    push_exp({32'h0000_0012, 32'h89AB_CDEF, 23'd4096}, 20);
    gap_q.delete(); last_sts_edge = -1;
    base = hs_count;
    wr(3'd0, 32'd2);
    wait_hs(base + 3);
    chk(gap_q.size() >= 2, "R5 gaps observed", gap_q.size(), 2);
    foreach (gap_q[i]) chk(gap_q[i] == 0, "R5 back-to-back gap", gap_q[i], 0);
    chk(state_code == 4'd1, "R11 continuous code", state_code, 1);
    wr(3'd0, 32'd0);
    idle(2);
    chk(state_code == 4'd2, "R9 draining", state_code, 2);
    base = hs_count;
    rcnt = 0; first_ok = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!first_ok && state_code != 4'd2) begin
        first_ok = 1;
        chk(state_code == 4'd3, "R9 enters mover reset", state_code, 3);
      end
      if (mover_rst) rcnt++;
    end
    chk(rcnt == FLUSH_CYC, "R9 reset pulse length", rcnt, FLUSH_CYC);
    chk(state_code == 4'd0, "R9 returns idle", state_code, 0);
    chk(hs_count == base, "R9 no reissue during stop", hs_count - base, 0);

    // R6 paced mode with gap 5
    wr(3'd4, 32'd5);
    wr(3'd3, 32'd2000);
    push_exp({32'h0000_0012, 32'h89AB_CDEF, 23'd2000}, 20);
    gap_q.delete(); last_sts_edge = -1;
    base = hs_count;
    wr(3'd0, 32'd3);
    wait_hs(base + 3);
    chk(gap_q.size() >= 2, "R6 gaps observed", gap_q.size(), 2);
    foreach (gap_q[i]) chk(gap_q[i] == 5, "R6 paced gap", gap_q[i], 5);
    for (int i = 0; i < 40 && state_code != 4'd6; i++) @(negedge clk);
    chk(state_code == 4'd6, "R6 gap code", state_code, 6);
    wr(3'd0, 32'd0);
    idle(40);
    chk(state_code == 4'd0, "R6 stop to idle", state_code, 0);

    // R9 stop coinciding with status acceptance in continuous mode
    wr(3'd3, 32'd512);
    push_exp({32'h0000_0012, 32'h89AB_CDEF, 23'd512}, 20);
    base = hs_count;
    wr(3'd0, 32'd2);
    wait_hs(base + 2);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1;
      if (busy && lat == STS_LAT - 2) break;
    end
    wr(3'd0, 32'd0);
    base = hs_count;
    saw_drain = 0; rcnt = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (state_code == 4'd2) saw_drain = 1;
      if (mover_rst) rcnt++;
    end
    chk(!saw_drain, "R9 coincident stop skips drain", saw_drain, 0);
    chk(rcnt == FLUSH_CYC, "R9 coincident reset pulse", rcnt, FLUSH_CYC);
    chk(hs_count == base, "R9 coincident no reissue", hs_count - base, 0);
    chk(state_code == 4'd0, "R9 coincident idle", state_code, 0);

    // R10 error status and sticky fault
    err_next = 1;
    push_exp({32'h0000_0012, 32'h89AB_CDEF, 23'd512}, 1);
    wr(3'd0, 32'd1);
    idle(30);
    chk(state_code == 4'd4, "R10 fault entered", state_code, 4);
    err_next = 0;
    base = hs_count;
    wr(3'd0, 32'd2);
    idle(10);
    chk(state_code == 4'd4, "R10 fault ignores run", state_code, 4);
    chk(hs_count == base, "R10 no command in fault", hs_count - base, 0);
    wr(3'd0, 32'd0);
    idle(2);
    chk(state_code == 4'd0, "R10 cleared by idle", state_code, 0);

    // R8 never valid with an outstanding command
    chk(ovl == 0, "R8 overlap count", ovl, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule